// File: doc/BRIEF.md
# Serial Transceiver Reset Sequencer

This block brings a multi-channel serial transceiver group out of reset after power-up. It drives four active-high controls: a power-down for the transmit PLL, a transmit digital reset, a receive analog reset and a receive digital reset. It releases them one at a time, in a fixed order, as the transceiver reports progress. The receiver recovers its clock automatically. Every minimum hold interval is a number of clock cycles and is set by a parameter.

Four status inputs arrive from other clock domains: PLL lock, a configuration busy flag, one frequency-lock flag per receive channel, and a receive-data-present indication. Each passes through a synchronizer before the sequencer acts on it. The transmit path is released once the PLL locks. The receive analog reset is released after busy has stayed low for a guard interval. The receive digital reset is released last. It needs every channel's frequency lock to be high together, then a settle interval, and also needs receive data to be present, so that the phase-compensation FIFOs cannot overflow or underflow.

The sequencer also recovers from faults without outside help. If a channel loses frequency lock while running, only the receive digital stage is reset again. If the PLL loses lock, the whole group restarts from power-down.

Top module: `xcvr_rst_seq`

## Requirements
- R1: After the master reset is released, the PLL power-down output stays high for exactly PWRDN_CYCLES clock cycles and then goes low.
- R2: While the PLL power-down output is high, the transmit digital, receive analog and receive digital resets are all high.
- R3: The transmit digital reset goes low only when the synchronized PLL lock is high. It stays high for as long as lock is absent.
- R4: The receive analog reset goes low only after the synchronized busy flag has been low for IDLE_GAP_CYCLES consecutive cycles (at least 2). A busy pulse restarts that count.
- R5: The receive digital reset stays high until all NUM_CH synchronized frequency-lock bits are high at the same time, even when they rise at different times.
- R6: Once all frequency-lock bits are high, SETTLE_CYCLES cycles pass before the receive digital reset can go low. A drop of any bit during that interval restarts the wait.
- R7: The receive digital reset is never released while the synchronized data-present input is low. The sequencer holds until data appears.
- R8: Every status input passes through a two-flop synchronizer. An input change can affect an output no earlier than the third rising clock edge after the change.
- R9: If any frequency-lock bit drops after the receive digital reset has been released, that reset goes high again on the next cycle, the transmit reset stays released, and the sequencer waits for frequency lock again.
- R10: If the synchronized PLL lock drops after the transmit digital reset has been released, all four outputs go high on the next cycle and the power-down interval of R1 starts again.
- R11: While the synchronous master reset is high, all four outputs are high from the next clock edge onward.
- R12: The resets are released in a fixed order. Receive analog reset is high whenever transmit digital reset is high, and receive digital reset is high whenever receive analog reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-domain clock |
| rst | input | 1 | Synchronous active-high master reset |
| pll_lock_i | input | 1 | Transmit PLL lock status (asynchronous) |
| cfg_busy_i | input | 1 | Configuration busy flag (asynchronous) |
| freq_lock_i | input | NUM_CH | Per-channel receive frequency lock (asynchronous) |
| rx_data_present_i | input | 1 | Receive data present at the pins (asynchronous) |
| tx_pll_pd_o | output | 1 | Transmit PLL power-down, active high |
| tx_dig_rst_o | output | 1 | Transmit digital reset, active high |
| rx_ana_rst_o | output | 1 | Receive analog reset, active high |
| rx_dig_rst_o | output | 1 | Receive digital reset, active high |

## Verification
The hardest states to reach from the ports are the ones deep in the receive phase: a frequency-lock bit dropping partway through the settle interval, and the settle count running out while no data is present. Each needs the whole earlier sequence to have completed. The stimulus first walks the group through power-down, PLL lock and a busy glitch. It then raises the lock bits one channel at a time, pulls one bit back inside the settle window, and holds data-present low past the end of the window before raising it. A behavioural model in the bench, including the two-cycle input delay, predicts every output on every cycle. It then adds a lock loss in the run state and a master reset partway through operation.

// File: rtl/xcvr_rst_pkg.sv
package xcvr_rst_pkg;

    // Sequencer phases, in release order.
    typedef enum logic [2:0] {
        ST_PWRDN     = 3'd0,
        ST_WAIT_PLL  = 3'd1,
        ST_WAIT_IDLE = 3'd2,
        ST_WAIT_FLK  = 3'd3,
        ST_SETTLE    = 3'd4,
        ST_RUN       = 3'd5
    } seq_state_e;

    // The four reset controls, all active high.
    typedef struct packed {
        logic pll_pd;
        logic tx_dig;
        logic rx_ana;
        logic rx_dig;
    } rst_outs_t;

    // Synchronized status bundle seen by the state machine.
    typedef struct packed {
        logic lock;
        logic busy;
        logic flk_all;
        logic data;
    } status_t;

    // Timer request issued by the state machine each cycle.
    typedef struct packed {
        logic clr;
        logic inc;
    } tmr_req_t;

    localparam rst_outs_t RST_ALL_ON = '{pll_pd: 1'b1, tx_dig: 1'b1, rx_ana: 1'b1, rx_dig: 1'b1};

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Output pattern for a given phase; each stage stays held until its own phase.
    function automatic rst_outs_t decode_outs(input seq_state_e s);
        rst_outs_t o;
        o.pll_pd = (s == ST_PWRDN);
        o.tx_dig = (s == ST_PWRDN) || (s == ST_WAIT_PLL);
        o.rx_ana = o.tx_dig || (s == ST_WAIT_IDLE);
        o.rx_dig = (s != ST_RUN);
        return o;
    endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= '0;
                    else     pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end

endmodule

// File: rtl/xrs_fsm.sv
module xrs_fsm
    import xcvr_rst_pkg::*;
#(
    parameter int PWRDN_CYCLES    = 32,
    parameter int IDLE_GAP_CYCLES = 2,
    parameter int SETTLE_CYCLES   = 64,
    parameter int CNT_W           = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  status_t          st_in,
    input  logic [CNT_W-1:0] count,
    output tmr_req_t         tmr,
    output rst_outs_t        outs
);

    localparam logic [CNT_W-1:0] PD_LAST  = CNT_W'(PWRDN_CYCLES - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(IDLE_GAP_CYCLES - 1);
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYCLES - 1);

    seq_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        tmr     = '{clr: 1'b0, inc: 1'b0};
        unique case (state_q)
            ST_PWRDN: begin
                if (count == PD_LAST) begin
                    state_n = ST_WAIT_PLL;
                    tmr.clr = 1'b1;
                end else begin
                    tmr.inc = 1'b1;
                end
            end
            ST_WAIT_PLL: begin
                if (st_in.lock) begin
                    state_n = ST_WAIT_IDLE;
                    tmr.clr = 1'b1;
                end
            end
            ST_WAIT_IDLE: begin
                if (!st_in.lock) begin
                    state_n = ST_PWRDN;
                    tmr.clr = 1'b1;
                end else if (st_in.busy) begin
                    tmr.clr = 1'b1;
                end else if (count == GAP_LAST) begin
                    state_n = ST_WAIT_FLK;
                    tmr.clr = 1'b1;
                end else begin
                    tmr.inc = 1'b1;
                end
            end
            ST_WAIT_FLK: begin
                if (!st_in.lock) begin
                    state_n = ST_PWRDN;
                    tmr.clr = 1'b1;
                end else if (st_in.flk_all) begin
                    state_n = ST_SETTLE;
                    tmr.clr = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!st_in.lock) begin
                    state_n = ST_PWRDN;
                    tmr.clr = 1'b1;
                end else if (!st_in.flk_all) begin
                    state_n = ST_WAIT_FLK;
                    tmr.clr = 1'b1;
                end else if (count >= SET_LAST) begin
                    if (st_in.data) begin
                        state_n = ST_RUN;
                        tmr.clr = 1'b1;
                    end
                end else begin
                    tmr.inc = 1'b1;
                end
            end
            ST_RUN: begin
                if (!st_in.lock) begin
                    state_n = ST_PWRDN;
                    tmr.clr = 1'b1;
                end else if (!st_in.flk_all) begin
                    state_n = ST_WAIT_FLK;
                    tmr.clr = 1'b1;
                end
            end
            default: begin
                state_n = ST_PWRDN;
                tmr.clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PWRDN;
            outs    <= RST_ALL_ON;
        end else begin
            state_q <= state_n;
            outs    <= decode_outs(state_n);
        end
    end

endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
    import xcvr_rst_pkg::*;
#(
    parameter int NUM_CH          = 4,
    parameter int SYNC_STAGES     = 2,
    parameter int PWRDN_CYCLES    = 32,
    parameter int IDLE_GAP_CYCLES = 2,
    parameter int SETTLE_CYCLES   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pll_lock_i,
    input  logic              cfg_busy_i,
    input  logic [NUM_CH-1:0] freq_lock_i,
    input  logic              rx_data_present_i,
    output logic              tx_pll_pd_o,
    output logic              tx_dig_rst_o,
    output logic              rx_ana_rst_o,
    output logic              rx_dig_rst_o
);

    localparam int SYNC_W = NUM_CH + 3;
    localparam int CNT_MAX = max3(PWRDN_CYCLES, IDLE_GAP_CYCLES, SETTLE_CYCLES);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    logic [SYNC_W-1:0] raw_vec, sync_vec;
    logic              lock_s, busy_s, data_s;
    logic [NUM_CH-1:0] flock_s;
    status_t           st_bus;
    tmr_req_t          tmr;
    logic [CNT_W-1:0]  count;
    rst_outs_t         outs;

    assign raw_vec = {rx_data_present_i, freq_lock_i, cfg_busy_i, pll_lock_i};

    xrs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_vec),
        .q   (sync_vec)
    );

    assign lock_s  = sync_vec[0];
    assign busy_s  = sync_vec[1];
    assign flock_s = sync_vec[NUM_CH+1:2];
    assign data_s  = sync_vec[NUM_CH+2];

    // Bonded group: all channels must report lock together.
    assign st_bus = '{lock: lock_s, busy: busy_s, flk_all: &flock_s, data: data_s};

    xrs_timer #(.CNT_W(CNT_W)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr.clr),
        .inc   (tmr.inc),
        .count (count)
    );

    xrs_fsm #(
        .PWRDN_CYCLES    (PWRDN_CYCLES),
        .IDLE_GAP_CYCLES (IDLE_GAP_CYCLES),
        .SETTLE_CYCLES   (SETTLE_CYCLES),
        .CNT_W           (CNT_W)
    ) fsm_i (
        .clk   (clk),
        .rst   (rst),
        .st_in (st_bus),
        .count (count),
        .tmr   (tmr),
        .outs  (outs)
    );

    assign tx_pll_pd_o  = outs.pll_pd;
    assign tx_dig_rst_o = outs.tx_dig;
    assign rx_ana_rst_o = outs.rx_ana;
    assign rx_dig_rst_o = outs.rx_dig;

endmodule

// File: rtl/xcvr_rst_seq_chk.sv
module xcvr_rst_seq_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_pll_pd_o,
    input logic              tx_dig_rst_o,
    input logic              rx_ana_rst_o,
    input logic              rx_dig_rst_o,
    input logic              lock_s,
    input logic              busy_s,
    input logic [NUM_CH-1:0] flock_s,
    input logic              data_s
);

    a_r2_pd_holds_all: assert property (@(posedge clk) disable iff (rst)
        tx_pll_pd_o |-> (tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o));

    a_r3_tx_needs_lock: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_dig_rst_o) |-> $past(lock_s));

    a_r4_busy_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_ana_rst_o) |-> (!$past(busy_s) && !$past(busy_s, 2)));

    a_r5_all_locked: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_dig_rst_o) |-> $past(&flock_s));

    a_r7_no_release_without_data: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_dig_rst_o) |-> $past(data_s));

    a_r9_flock_drop: assert property (@(posedge clk) disable iff (rst)
        (!rx_dig_rst_o && !(&flock_s)) |=> rx_dig_rst_o);

    a_r10_lock_loss: assert property (@(posedge clk) disable iff (rst)
        (!tx_dig_rst_o && !lock_s) |=> (tx_pll_pd_o && tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o));

    a_r11_master_reset: assert property (@(posedge clk)
        rst |=> (tx_pll_pd_o && tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o));

    a_r12_order_tx_rxa: assert property (@(posedge clk) disable iff (rst)
        tx_dig_rst_o |-> rx_ana_rst_o);

    a_r12_order_rxa_rxd: assert property (@(posedge clk) disable iff (rst)
        rx_ana_rst_o |-> rx_dig_rst_o);

endmodule

bind xcvr_rst_seq xcvr_rst_seq_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .tx_pll_pd_o  (tx_pll_pd_o),
    .tx_dig_rst_o (tx_dig_rst_o),
    .rx_ana_rst_o (rx_ana_rst_o),
    .rx_dig_rst_o (rx_dig_rst_o),
    .lock_s       (lock_s),
    .busy_s       (busy_s),
    .flock_s      (flock_s),
    .data_s       (data_s)
);

// File: tb/xcvr_rst_seq_tb_top.sv
`timescale 1ns/1ps
module xcvr_rst_seq_tb_top;

    localparam int NCH = 4;
    localparam int PD  = 8;
    localparam int GAP = 3;
    localparam int SET = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           lock = 1'b0;
    logic           busy = 1'b1;
    logic [NCH-1:0] flk = '0;
    logic           dat = 1'b0;
    logic           pd_o, txd_o, rxa_o, rxd_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit started = 0;

    always #2 clk = ~clk;

    xcvr_rst_seq #(
        .NUM_CH(NCH), .SYNC_STAGES(2), .PWRDN_CYCLES(PD),
        .IDLE_GAP_CYCLES(GAP), .SETTLE_CYCLES(SET)
    ) dut_i (
        .clk(clk), .rst(rst), .pll_lock_i(lock), .cfg_busy_i(busy),
        .freq_lock_i(flk), .rx_data_present_i(dat),
        .tx_pll_pd_o(pd_o), .tx_dig_rst_o(txd_o),
        .rx_ana_rst_o(rxa_o), .rx_dig_rst_o(rxd_o)
    );

    // Reference model: phase number 0..5, input delay queues of depth two.
    int   m_ph = 0;
    int   m_cnt = 0;
    logic q_lock[$], q_busy[$], q_dat[$];
    logic q_all[$];

    function automatic logic exp_pd();  return m_ph == 0; endfunction
    function automatic logic exp_txd(); return m_ph <= 1; endfunction
    function automatic logic exp_rxa(); return m_ph <= 2; endfunction
    function automatic logic exp_rxd(); return m_ph != 5; endfunction

    always @(posedge clk) begin
        logic sl, sb, sa, sd;
        cycles++;
        started = 1;
        if (rst) begin
            m_ph = 0; m_cnt = 0;
            q_lock = '{0, 0}; q_busy = '{0, 0}; q_all = '{0, 0}; q_dat = '{0, 0};
        end else begin
            sl = q_lock[0]; sb = q_busy[0]; sa = q_all[0]; sd = q_dat[0];
            if (m_ph >= 2 && !sl) begin
                m_ph = 0; m_cnt = 0;
            end else if (m_ph == 0) begin
                if (m_cnt == PD - 1) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
            end else if (m_ph == 1) begin
                if (sl) begin m_ph = 2; m_cnt = 0; end
            end else if (m_ph == 2) begin
                if (sb) m_cnt = 0;
                else if (m_cnt == GAP - 1) begin m_ph = 3; m_cnt = 0; end
                else m_cnt++;
            end else if (m_ph == 3) begin
                if (sa) begin m_ph = 4; m_cnt = 0; end
            end else if (m_ph == 4) begin
                if (!sa) begin m_ph = 3; m_cnt = 0; end
                else if (m_cnt >= SET - 1) begin
                    if (sd) begin m_ph = 5; m_cnt = 0; end
                end else m_cnt++;
            end else begin
                if (!sa) begin m_ph = 3; m_cnt = 0; end
            end
            void'(q_lock.pop_front()); void'(q_busy.pop_front());
            void'(q_all.pop_front());  void'(q_dat.pop_front());
            q_lock.push_back(lock); q_busy.push_back(busy);
            q_all.push_back(&flk);  q_dat.push_back(dat);
        end
        if (cycles > 60000) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=60000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at t=%0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Every cycle: compare against the model, and the ordering rules.
    always @(negedge clk) begin
        if (started) begin
            chk("R1 pll power-down", pd_o, exp_pd());
            chk("R3 R8 R10 tx digital reset", txd_o, exp_txd());
            chk("R4 rx analog reset", rxa_o, exp_rxa());
            chk("R5 R6 R7 R9 rx digital reset", rxd_o, exp_rxd());
            if (pd_o === 1'b1) chk("R2 others held during power-down", txd_o & rxa_o & rxd_o, 1'b1);
            if (txd_o === 1'b1) chk("R12 rx analog held while tx held", rxa_o, 1'b1);
            if (rxa_o === 1'b1) chk("R12 rx digital held while rx analog held", rxd_o, 1'b1);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        chk("R11 reset state pd", pd_o, 1'b1);
        chk("R11 reset state rxd", rxd_o, 1'b1);
        rst = 1'b0;
        wait_n(PD - 1);
        chk("R1 power-down still high", pd_o, 1'b1);
        wait_n(1);
        chk("R1 power-down released", pd_o, 1'b0);
        wait_n(6);
        chk("R3 tx held without lock", txd_o, 1'b1);
        lock = 1'b1;
        wait_n(2);
        chk("R8 two edges not enough", txd_o, 1'b1);
        wait_n(1);
        chk("R3 tx released after lock", txd_o, 1'b0);
        wait_n(5);
        chk("R4 rx analog held while busy", rxa_o, 1'b1);
        busy = 1'b0;
        wait_n(2);
        busy = 1'b1;
        wait_n(1);
        busy = 1'b0;
        wait_n(3);
        chk("R4 busy pulse restarted gap", rxa_o, 1'b1);
        wait_n(4);
        chk("R4 rx analog released", rxa_o, 1'b0);
        for (int c = 0; c < NCH; c++) begin
            flk[c] = 1'b1;
            wait_n(4);
            chk("R5 rx digital held until all locked", rxd_o, 1'b1);
        end
        wait_n(3);
        flk[2] = 1'b0;
        wait_n(2);
        flk[2] = 1'b1;
        wait_n(SET - 2);
        chk("R6 settle restarted after drop", rxd_o, 1'b1);
        wait_n(12);
        chk("R7 held without data", rxd_o, 1'b1);
        dat = 1'b1;
        wait_n(4);
        chk("R7 released once data present", rxd_o, 1'b0);
        flk[0] = 1'b0;
        wait_n(4);
        chk("R9 rx digital reasserted", rxd_o, 1'b1);
        chk("R9 tx stays released", txd_o, 1'b0);
        flk[0] = 1'b1;
        wait_n(SET + 6);
        chk("R6 re-release after settle", rxd_o, 1'b0);
        lock = 1'b0;
        wait_n(4);
        chk("R10 power-down restarted", pd_o, 1'b1);
        chk("R10 tx reset reasserted", txd_o, 1'b1);
        wait_n(3);
        lock = 1'b1;
        wait_n(PD + GAP + SET + 20);
        chk("R10 full recovery to run", rxd_o, 1'b0);
        rst = 1'b1;
        wait_n(2);
        chk("R11 mid-run reset pd", pd_o, 1'b1);
        chk("R11 mid-run reset rxa", rxa_o, 1'b1);
        rst = 1'b0;
        wait_n(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule